// File: doc/BRIEF.md
# Counter Write-Bypass Buffer

This block sits in front of a single-port table of saturating prediction counters. Training updates arrive long after the prediction that read the counter, so the counter value carried with an update may be stale. The most common case is a branch that trains several times in quick succession. The buffer keeps the most recent written value of a small set of table entries. Each update looks up its key in the buffer. On a hit, the buffered value replaces the value that came with the update.

Every accepted update steps its counter toward the resolved direction, saturating at both ends. The result is written into the buffer and offered to the table-write port one cycle later. A table write is withheld for any slot whose counter was already pinned at its limit and so did not change. Parameters select the following:
- depth;
- index, tag and counter widths;
- signed or unsigned counters;
- a tagless mode that compares the index only;
- the number of counters held per entry, for blocks that train two branch slots together.

Top module: `ctr_wr_bypass`

## Requirements
- R1: After reset every buffer entry is invalid, no table write is presented, and the replacement pointer is at entry 0. The first update after reset therefore always misses.
- R2: An accepted update produces its table-write result on the output registers in the following cycle. The result carries the update's index and tag.
- R3: An entry hits only when it is valid and its stored index equals the update index. In tagged mode (TAGGED=1) the stored tag must also equal the update tag. In tagless mode the tag is not compared.
- R4: On a hit, the stored counter is the starting value and the supplied old counter is discarded. On a miss, the supplied old counter is the starting value.
- R5: An unsigned counter of CTR_W bits (default 3 bits, range 0..7) goes up by one when taken and down by one when not taken, and holds at 0 and at 2^CTR_W-1.
- R6: With SIGNED_CTR=1 the counter is two's complement, ranging from -2^(CTR_W-1) to 2^(CTR_W-1)-1. For 6 bits that is -32..31, with -32 written as 6'h20 and 31 as 6'h1F. It saturates at both ends.
- R7: Bit s of tbl_wr_mask is set only when slot s is enabled and its new counter differs from its starting value. tbl_wr_en is high only when some mask bit is set. The buffer records the result even when the table write is withheld.
- R8: A miss allocates the entry at the replacement pointer, and the pointer then advances round-robin through 0..DEPTH-1. A hit rewrites its own entry and leaves the pointer where it is.
- R9: Slot s occupies bits [s*CTR_W +: CTR_W] of every counter bus. On a hit, a slot that is not enabled keeps its buffered counter. On a miss, that slot is filled with its supplied counter. In both cases tbl_wr_ctr carries the slot's starting value.
- R10: An update with upd_valid low, or with no slot enabled, changes no buffer state and produces no table write.
- R11: An update in the cycle right after another update to the same key starts from the value that update produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid | input | 1 | Training update present this cycle |
| upd_slot_en | input | SLOTS | Per-slot enable for the counters being trained |
| upd_index | input | IDX_W | Table index of the update |
| upd_tag | input | TAG_W | Partial tag of the update (compared only when TAGGED=1) |
| upd_old_ctr | input | SLOTS*CTR_W | Counter values carried with the update |
| upd_taken | input | SLOTS | Resolved direction per slot, 1 = taken |
| tbl_wr_en | output | 1 | Table write request |
| tbl_wr_index | output | IDX_W | Table write index |
| tbl_wr_tag | output | TAG_W | Table write tag |
| tbl_wr_mask | output | SLOTS | Slots whose counter changed |
| tbl_wr_ctr | output | SLOTS*CTR_W | Written counter values |

## Verification
The assertions assume that updates hold their key and counters steady for the single cycle they are presented. They also assume that reset is applied before the first update. Under those assumptions they expect the key array never to hold a key twice. That expectation rests on allocation happening only on a miss, so it holds for any input sequence. The stimulus drives every input at the falling edge, one update per cycle. It works inside a key space small enough to force hits, aliasing and eviction, and a reference model tracks buffer contents and pointer position for every update.

// File: rtl/ctr_wr_bypass_pkg.sv
package ctr_wr_bypass_pkg;

    localparam int unsigned CWB_MAX_CTR_W = 8;

    typedef logic [CWB_MAX_CTR_W-1:0] cwb_ctr_t;

    typedef enum logic [0:0] {
        CWB_UNSIGNED = 1'b0,
        CWB_SIGNED   = 1'b1
    } cwb_ctr_kind_e;

    // One saturating step on a counter of width w held in the low bits of v.
    function automatic cwb_ctr_t cwb_sat_step(input cwb_ctr_t v, input logic up,
                                              input int unsigned w, input cwb_ctr_kind_e kind);
        logic [CWB_MAX_CTR_W:0] full;
        cwb_ctr_t mask;
        cwb_ctr_t hi;
        cwb_ctr_t lo;
        full = ({{CWB_MAX_CTR_W{1'b0}}, 1'b1} << w) - {{CWB_MAX_CTR_W{1'b0}}, 1'b1};
        mask = full[CWB_MAX_CTR_W-1:0];
        if (kind == CWB_SIGNED) begin
            hi = mask >> 1;
            lo = (mask >> 1) ^ mask;
        end else begin
            hi = mask;
            lo = '0;
        end
        if (up) begin
            return (v == hi) ? v : ((v + cwb_ctr_t'(1)) & mask);
        end
        return (v == lo) ? v : ((v - cwb_ctr_t'(1)) & mask);
    endfunction

endpackage

// File: rtl/ctr_wr_bypass_cam.sv
module ctr_wr_bypass_cam #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned KEY_W = 19,
    parameter int unsigned PTR_W = 3
) (
    input  logic [DEPTH-1:0][KEY_W-1:0] keys,
    input  logic [DEPTH-1:0]            vld,
    input  logic [KEY_W-1:0]            query,
    output logic [DEPTH-1:0]            match_vec,
    output logic                        hit,
    output logic [PTR_W-1:0]            hit_way
);

    for (genvar w = 0; w < DEPTH; w++) begin : g_cmp
        assign match_vec[w] = vld[w] && (keys[w] == query);
    end

    assign hit = |match_vec;

    // Keys are unique, so an OR-encode of the match vector is exact.
    always_comb begin
        hit_way = '0;
        for (int w = 0; w < DEPTH; w++) begin
            if (match_vec[w]) begin
                hit_way = hit_way | PTR_W'(w);
            end
        end
    end

endmodule

// File: rtl/ctr_wr_bypass_victim.sv
module ctr_wr_bypass_victim #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned PTR_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc,
    output logic [PTR_W-1:0] ptr
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (alloc) begin
            ptr <= (ptr == LAST) ? '0 : ptr + PTR_W'(1);
        end
    end

endmodule

// File: rtl/ctr_wr_bypass_slot.sv
module ctr_wr_bypass_slot
    import ctr_wr_bypass_pkg::*;
#(
    parameter int unsigned CTR_W      = 3,
    parameter bit          SIGNED_CTR = 1'b0
) (
    input  logic [CTR_W-1:0] stored_ctr,
    input  logic [CTR_W-1:0] supplied_ctr,
    input  logic             use_stored,
    input  logic             enable,
    input  logic             taken,
    output logic [CTR_W-1:0] base_ctr,
    output logic [CTR_W-1:0] next_ctr,
    output logic             changed
);

    localparam cwb_ctr_kind_e KIND = SIGNED_CTR ? CWB_SIGNED : CWB_UNSIGNED;

    cwb_ctr_t stepped_wide;
    logic [CTR_W-1:0] stepped;

    assign base_ctr     = use_stored ? stored_ctr : supplied_ctr;
    assign stepped_wide = cwb_sat_step(cwb_ctr_t'(base_ctr), taken, CTR_W, KIND);
    assign stepped      = stepped_wide[CTR_W-1:0];
    assign next_ctr     = enable ? stepped : base_ctr;
    assign changed      = enable && (stepped != base_ctr);

endmodule

// File: rtl/ctr_wr_bypass.sv
module ctr_wr_bypass
    import ctr_wr_bypass_pkg::*;
#(
    parameter int unsigned DEPTH      = 8,
    parameter int unsigned IDX_W      = 11,
    parameter int unsigned TAG_W      = 8,
    parameter int unsigned CTR_W      = 3,
    parameter int unsigned SLOTS      = 1,
    parameter bit          TAGGED     = 1'b1,
    parameter bit          SIGNED_CTR = 1'b0
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   upd_valid,
    input  logic [SLOTS-1:0]       upd_slot_en,
    input  logic [IDX_W-1:0]       upd_index,
    input  logic [TAG_W-1:0]       upd_tag,
    input  logic [SLOTS*CTR_W-1:0] upd_old_ctr,
    input  logic [SLOTS-1:0]       upd_taken,
    output logic                   tbl_wr_en,
    output logic [IDX_W-1:0]       tbl_wr_index,
    output logic [TAG_W-1:0]       tbl_wr_tag,
    output logic [SLOTS-1:0]       tbl_wr_mask,
    output logic [SLOTS*CTR_W-1:0] tbl_wr_ctr
);

    localparam int unsigned PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned KEY_W  = TAGGED ? (IDX_W + TAG_W) : IDX_W;
    localparam int unsigned DATA_W = SLOTS * CTR_W;

    // Storage: keys and counters share a slot number.
    logic [DEPTH-1:0][KEY_W-1:0] key_q;
    logic [DATA_W-1:0]           data_q [DEPTH];
    logic [DEPTH-1:0]            vld_q;

    logic              fire;
    logic [KEY_W-1:0]  query_key;
    logic [DEPTH-1:0]  match_vec;
    logic              lk_hit;
    logic [PTR_W-1:0]  hit_way;
    logic [PTR_W-1:0]  ptr;
    logic [PTR_W-1:0]  wr_way;
    logic [DATA_W-1:0] hit_data;
    logic [DATA_W-1:0] base_data;
    logic [DATA_W-1:0] next_data;
    logic [SLOTS-1:0]  slot_wr;

    assign fire = upd_valid && (|upd_slot_en);

    if (TAGGED) begin : g_key_tagged
        assign query_key = {upd_tag, upd_index};
    end else begin : g_key_index
        assign query_key = upd_index;
    end

    ctr_wr_bypass_cam #(
        .DEPTH (DEPTH),
        .KEY_W (KEY_W),
        .PTR_W (PTR_W)
    ) u_cam (
        .keys      (key_q),
        .vld       (vld_q),
        .query     (query_key),
        .match_vec (match_vec),
        .hit       (lk_hit),
        .hit_way   (hit_way)
    );

    ctr_wr_bypass_victim #(
        .DEPTH (DEPTH),
        .PTR_W (PTR_W)
    ) u_victim (
        .clk   (clk),
        .rst   (rst),
        .alloc (fire && !lk_hit),
        .ptr   (ptr)
    );

    assign wr_way   = lk_hit ? hit_way : ptr;
    assign hit_data = data_q[hit_way];

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        ctr_wr_bypass_slot #(
            .CTR_W      (CTR_W),
            .SIGNED_CTR (SIGNED_CTR)
        ) u_slot (
            .stored_ctr   (hit_data[s*CTR_W +: CTR_W]),
            .supplied_ctr (upd_old_ctr[s*CTR_W +: CTR_W]),
            .use_stored   (lk_hit),
            .enable       (upd_slot_en[s]),
            .taken        (upd_taken[s]),
            .base_ctr     (base_data[s*CTR_W +: CTR_W]),
            .next_ctr     (next_data[s*CTR_W +: CTR_W]),
            .changed      (slot_wr[s])
        );
    end

    // Buffer update: a hit rewrites in place, a miss takes the victim slot.
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else if (fire) begin
            key_q[wr_way]  <= query_key;
            data_q[wr_way] <= next_data;
            vld_q[wr_way]  <= 1'b1;
        end
    end

    // Table-write port, one register stage after the update.
    always_ff @(posedge clk) begin
        if (rst) begin
            tbl_wr_en    <= 1'b0;
            tbl_wr_index <= '0;
            tbl_wr_tag   <= '0;
            tbl_wr_mask  <= '0;
            tbl_wr_ctr   <= '0;
        end else begin
            tbl_wr_en <= fire && (|slot_wr);
            if (fire) begin
                tbl_wr_index <= upd_index;
                tbl_wr_tag   <= upd_tag;
                tbl_wr_mask  <= slot_wr;
                tbl_wr_ctr   <= next_data;
            end
        end
    end

    logic unused_base;
    assign unused_base = ^base_data;

endmodule

// File: rtl/ctr_wr_bypass_chk.sv
module ctr_wr_bypass_chk #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned PTR_W = 3,
    parameter int unsigned SLOTS = 1
) (
    input logic             clk,
    input logic             rst,
    input logic             fire,
    input logic             lk_hit,
    input logic [PTR_W-1:0] hit_way,
    input logic [DEPTH-1:0] match_vec,
    input logic [DEPTH-1:0] vld_q,
    input logic [PTR_W-1:0] ptr,
    input logic [SLOTS-1:0] upd_slot_en,
    input logic             tbl_wr_en,
    input logic [SLOTS-1:0] tbl_wr_mask
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    a_r2_write_follows_update: assert property (@(posedge clk) disable iff (rst)
        tbl_wr_en |-> $past(fire));

    a_r10_idle_no_write: assert property (@(posedge clk) disable iff (rst)
        !fire |=> !tbl_wr_en);

    a_r3_hit_needs_valid: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> vld_q[hit_way]);

    a_r8_unique_keys: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match_vec));

    a_r8_miss_advances: assert property (@(posedge clk) disable iff (rst)
        (fire && !lk_hit) |=> (ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + PTR_W'(1))));

    a_r8_hit_holds_ptr: assert property (@(posedge clk) disable iff (rst)
        (fire && lk_hit) |=> $stable(ptr));

    a_r7_mask_within_enables: assert property (@(posedge clk) disable iff (rst)
        tbl_wr_en |-> ((tbl_wr_mask & ~$past(upd_slot_en)) == '0));

    a_r7_enable_has_mask: assert property (@(posedge clk) disable iff (rst)
        tbl_wr_en |-> (tbl_wr_mask != '0));

endmodule

bind ctr_wr_bypass ctr_wr_bypass_chk #(
    .DEPTH (DEPTH),
    .PTR_W (PTR_W),
    .SLOTS (SLOTS)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .fire        (fire),
    .lk_hit      (lk_hit),
    .hit_way     (hit_way),
    .match_vec   (match_vec),
    .vld_q       (vld_q),
    .ptr         (ptr),
    .upd_slot_en (upd_slot_en),
    .tbl_wr_en   (tbl_wr_en),
    .tbl_wr_mask (tbl_wr_mask)
);

// File: tb/ctr_wr_bypass_tb.sv
`timescale 1ns/1ps
module ctr_wr_bypass_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    // Default configuration: 8 entries, 11-bit index, 8-bit tag, 3-bit unsigned.
    logic        upd_valid = 1'b0;
    logic [0:0]  upd_slot_en = 1'b0;
    logic [10:0] upd_index = '0;
    logic [7:0]  upd_tag = '0;
    logic [2:0]  upd_old_ctr = '0;
    logic [0:0]  upd_taken = 1'b0;
    logic        tbl_wr_en;
    logic [10:0] tbl_wr_index;
    logic [7:0]  tbl_wr_tag;
    logic [0:0]  tbl_wr_mask;
    logic [2:0]  tbl_wr_ctr;

    ctr_wr_bypass u_dut (
        .clk(clk), .rst(rst), .upd_valid(upd_valid), .upd_slot_en(upd_slot_en),
        .upd_index(upd_index), .upd_tag(upd_tag), .upd_old_ctr(upd_old_ctr),
        .upd_taken(upd_taken), .tbl_wr_en(tbl_wr_en), .tbl_wr_index(tbl_wr_index),
        .tbl_wr_tag(tbl_wr_tag), .tbl_wr_mask(tbl_wr_mask), .tbl_wr_ctr(tbl_wr_ctr)
    );

    // Variant: 16 entries, tagless, two slots of 6-bit signed counters.
    logic        v_valid = 1'b0;
    logic [1:0]  v_slot_en = '0;
    logic [7:0]  v_index = '0;
    logic [7:0]  v_tag = '0;
    logic [11:0] v_old = '0;
    logic [1:0]  v_taken = '0;
    logic        v_wr_en;
    logic [7:0]  v_wr_index;
    logic [7:0]  v_wr_tag;
    logic [1:0]  v_wr_mask;
    logic [11:0] v_wr_ctr;

    ctr_wr_bypass #(
        .DEPTH(16), .IDX_W(8), .TAG_W(8), .CTR_W(6), .SLOTS(2),
        .TAGGED(1'b0), .SIGNED_CTR(1'b1)
    ) u_dut2 (
        .clk(clk), .rst(rst), .upd_valid(v_valid), .upd_slot_en(v_slot_en),
        .upd_index(v_index), .upd_tag(v_tag), .upd_old_ctr(v_old),
        .upd_taken(v_taken), .tbl_wr_en(v_wr_en), .tbl_wr_index(v_wr_index),
        .tbl_wr_tag(v_wr_tag), .tbl_wr_mask(v_wr_mask), .tbl_wr_ctr(v_wr_ctr)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference model of the default instance.
    int m_idx [8];
    int m_tag [8];
    int m_ctr [8];
    bit m_vld [8];
    int m_ptr = 0;

    bit    p_pend = 1'b0;
    bit    p_en;
    int    p_idx;
    int    p_tag;
    int    p_ctr;
    string p_req;

    task automatic check_pending();
        if (p_pend) begin
            chk(tbl_wr_en == p_en, {p_req, " wr_en"}, int'(tbl_wr_en), int'(p_en));
            if (p_en) begin
                chk(int'(tbl_wr_ctr) == p_ctr, {p_req, " ctr"}, int'(tbl_wr_ctr), p_ctr);
                chk(int'(tbl_wr_index) == p_idx && int'(tbl_wr_tag) == p_tag,
                    {p_req, " R2 key"}, int'(tbl_wr_index), p_idx);
            end
        end
    endtask

    task automatic upd(input bit v, input bit en, input int idx, input int tag,
                       input int old, input bit tk, input string req);
        int hw;
        int base;
        int nw;
        check_pending();
        upd_valid   = v;
        upd_slot_en = en;
        upd_index   = 11'(idx);
        upd_tag     = 8'(tag);
        upd_old_ctr = 3'(old);
        upd_taken   = tk;
        p_pend = 1'b1;
        p_req  = req;
        p_en   = 1'b0;
        if (v && en) begin
            hw = -1;
            for (int w = 0; w < 8; w++) begin
                if (m_vld[w] && m_idx[w] == idx && m_tag[w] == tag) hw = w;
            end
            base = (hw >= 0) ? m_ctr[hw] : old;
            if (tk) nw = (base == 7) ? 7 : base + 1;
            else    nw = (base == 0) ? 0 : base - 1;
            p_en  = (nw != base);
            p_idx = idx;
            p_tag = tag;
            p_ctr = nw;
            if (hw < 0) begin
                hw = m_ptr;
                m_ptr = (m_ptr + 1) % 8;
            end
            m_idx[hw] = idx;
            m_tag[hw] = tag;
            m_ctr[hw] = nw;
            m_vld[hw] = 1'b1;
        end
        @(negedge clk);
    endtask

    // Variant step: drive, wait one cycle, compare.
    task automatic vstep(input bit en_exp, input logic [1:0] mask_exp,
                         input logic [11:0] ctr_exp, input logic [11:0] ctr_care,
                         input string req);
        @(negedge clk);
        chk(v_wr_en == en_exp, {req, " wr_en"}, int'(v_wr_en), int'(en_exp));
        if (en_exp) begin
            chk(v_wr_mask == mask_exp, {req, " mask"}, int'(v_wr_mask), int'(mask_exp));
            chk((v_wr_ctr & ctr_care) == (ctr_exp & ctr_care), {req, " ctr"},
                int'(v_wr_ctr & ctr_care), int'(ctr_exp & ctr_care));
        end
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        for (int w = 0; w < 8; w++) m_vld[w] = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state.
        chk(tbl_wr_en == 1'b0, "R1 reset wr_en", int'(tbl_wr_en), 0);
        chk(v_wr_en == 1'b0, "R1 reset variant wr_en", int'(v_wr_en), 0);
        rst = 1'b0;

        // R1: first update misses and uses the supplied value.
        upd(1, 1, 0, 0, 5, 1, "R1 first miss");

        // R5 R7: every starting value and direction on fresh keys.
        for (int o = 0; o < 8; o++) begin
            for (int t = 0; t < 2; t++) begin
                upd(1, 1, 300 + o * 2 + t, 7, o, t[0], "R5 R7 step sweep");
            end
        end

        // R11 R4: back-to-back hits with a stale supplied value.
        for (int k = 0; k < 9; k++) upd(1, 1, 400, 3, 0, 1, "R11 R4 up chain");
        for (int k = 0; k < 9; k++) upd(1, 1, 400, 3, 7, 0, "R11 R4 down chain");

        // R3: same index, other tag misses.
        upd(1, 1, 400, 4, 2, 1, "R3 tag mismatch");
        upd(1, 1, 401, 3, 2, 1, "R3 index mismatch");

        // R10: ignored updates leave the stored value alone.
        upd(1, 1, 200, 9, 2, 1, "R10 setup");
        upd(1, 0, 200, 9, 0, 0, "R10 no slot enabled");
        upd(0, 1, 200, 9, 0, 0, "R10 valid low");
        upd(1, 1, 200, 9, 0, 1, "R10 R4 stored kept");

        // R8: fill, evict oldest, hit leaves pointer.
        for (int k = 0; k < 8; k++) upd(1, 1, 100 + k, 1, 3, 1, "R8 fill");
        upd(1, 1, 108, 1, 3, 1, "R8 evict");
        upd(1, 1, 101, 1, 0, 1, "R8 hit survivor");
        upd(1, 1, 100, 1, 0, 1, "R8 evicted key misses");
        upd(1, 1, 101, 1, 6, 0, "R8 pointer held then evicts");

        // R4 R11: pseudo-random sweep over a small key space.
        lfsr = 16'hACE1;
        for (int k = 0; k < 600; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            upd(lfsr[2:0] != 3'd0, lfsr[6:3] != 4'd0, int'(lfsr[8:7]), int'(lfsr[9]),
                int'(lfsr[12:10]), lfsr[13], "R4 R11 random");
        end
        upd(0, 0, 0, 0, 0, 0, "R2 drain");
        check_pending();
        p_pend = 1'b0;

        // R6 R9 R3: variant instance, signed two-slot tagless.
        v_valid = 1'b1; v_index = 8'd5; v_tag = 8'd1;
        v_slot_en = 2'b01; v_taken = 2'b01; v_old = {6'd0, 6'h1F};
        vstep(1'b0, 2'b00, 12'h000, 12'h000, "R6 signed top saturated");
        v_slot_en = 2'b10; v_taken = 2'b00; v_old = {6'h20, 6'd0}; v_tag = 8'd77;
        vstep(1'b1, 2'b10, {6'h3F, 6'h1F}, 12'hFFF, "R3 R9 tagless hit slot1");
        v_slot_en = 2'b01; v_taken = 2'b00; v_old = 12'h000;
        vstep(1'b1, 2'b01, {6'h3F, 6'h1E}, 12'hFFF, "R9 slot0 kept");
        v_index = 8'd9; v_slot_en = 2'b10; v_taken = 2'b00; v_old = {6'h20, 6'd3};
        vstep(1'b0, 2'b00, 12'h000, 12'h000, "R6 signed bottom saturated");
        v_slot_en = 2'b10; v_taken = 2'b10; v_old = 12'h000;
        vstep(1'b1, 2'b10, {6'h21, 6'd3}, 12'hFFF, "R6 R4 leave bottom");
        v_slot_en = 2'b11; v_taken = 2'b11; v_old = 12'h000;
        vstep(1'b1, 2'b11, {6'h22, 6'd4}, 12'hFFF, "R9 both slots");
        v_valid = 1'b0;
        vstep(1'b0, 2'b00, 12'h000, 12'h000, "R10 variant idle");

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule